// File: doc/BRIEF.md
# I2C Short-Transaction Offload Bridge

This block runs a complete I2C master transfer of one to eight payload bytes without per-byte software work. Software loads up to two 32-bit transmit words, then writes one control word that holds the direction, the target address, the address width, the byte count and a launch bit. The bridge then issues commands to the neighbouring I2C byte engine: start, one or two address bytes, the payload bytes, and a stop. At the end it latches a completion cause bit, an error status bit and, on a read, the received bytes. Received bytes land little-endian in two 32-bit receive words.

The byte engine is reached through a command handshake. The bridge holds `eng_valid_o` with a command, a data byte and an acknowledge choice until the engine returns `eng_done_i` for one cycle. On a write command the engine also reports whether the target refused the byte, and on a read command it returns the byte it received. A single interrupt line is the completion cause gated by a mask bit.

Top module: `i2c_txn_bridge`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and no engine command is offered. Register indices: 0 control, 1 status, 2 cause, 3 mask, 4 transmit low word, 5 transmit high word, 6 receive low word, 7 receive high word.
- R2: Control word fields: bit 0 write, bit 1 read, bits 11:2 target address, bit 12 ten-bit address, bits 15:13 write count minus one, bits 18:16 read count minus one, bit 19 launch. A control write launches a transfer only when bit 19 is set. While a transfer runs, the control register reads back with bit 19 set.
- R3: A write transfer issues these commands in order: START (code 0), WRITE (code 1) of {addr[6:0], 0}, WRITE of each payload byte, STOP (code 3). Payload byte k is transmit-low bits 8k+7:8k for k<4, and transmit-high bits 8(k-4)+7:8(k-4) for k>=4.
- R4: With bit 12 set, the address phase is two WRITE commands: first {5'b11110, addr[9:8], dir}, then addr[7:0]. Here dir is 0 for a write and 1 for a read.
- R5: A read issues READ (code 2) commands, one for each byte. The acknowledge request is 1 on every byte except the last, where it is 0. Received byte k is stored in the receive words at the same position R3 uses for payload byte k. All receive bytes are cleared at launch.
- R6: If the target refuses the address or any write byte, the next command is STOP, no further byte is sent, and status bit 0 reads 1 after completion.
- R7: Each transfer sets cause bit 0 exactly once at its end. `irq_o` equals cause bit 0 AND mask bit 0.
- R8: Writes to control or to a transmit word are ignored while a transfer runs, and control writes are also ignored while cause bit 0 is set. After the cause bit is cleared, a new launch is accepted.
- R9: A cause write with bit 0 equal to 0 clears the cause bit, and `irq_o` drops.
- R10: A launch with both direction bits set, or with neither set, starts no transfer.
- R11: Status bit 0 is cleared when the next transfer launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on index) |
| irq_o | output | 1 | Completion interrupt |
| eng_valid_o | output | 1 | Command offered to byte engine |
| eng_cmd_o | output | 2 | Command: 0 start, 1 write, 2 read, 3 stop |
| eng_wdata_o | output | 8 | Byte to send on a write command |
| eng_ack_o | output | 1 | On read: 1 acknowledge the byte, 0 refuse it |
| eng_done_i | input | 1 | Engine finished the offered command |
| eng_nack_i | input | 1 | Target refused the written byte (valid with done) |
| eng_rdata_i | input | 8 | Byte received (valid with done on read) |

## Verification
The hardest situations to reach are the ones where a register write collides with bridge activity. One case is a launch written during a transfer. The other is a launch written in the window after the transfer has ended but before its cause bit is cleared. The bench uses a byte-engine model with fixed latency and writes the second command while the first transfer is mid-payload, and again while the cause is pending. It then checks that the command log holds only the first transfer. Refusals are injected at a chosen command index, so the model can reject an address byte or a particular payload byte.

// File: rtl/obr_pkg.sv
package obr_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 2;
  localparam int NUM_BYTES = NUM_WORDS * WORD_W / 8;
  localparam int IDX_W     = $clog2(NUM_BYTES);
  localparam int REG_AW    = 3;
  localparam int ADDR_W    = 10;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT  = 3'd1;
  localparam logic [REG_AW-1:0] RA_CAUSE = 3'd2;
  localparam logic [REG_AW-1:0] RA_MASK  = 3'd3;
  localparam logic [REG_AW-1:0] RA_TX0   = 3'd4;
  localparam logic [REG_AW-1:0] RA_RX0   = 3'd6;

  localparam int CB_WR    = 0;
  localparam int CB_RD    = 1;
  localparam int CB_ADDR  = 2;
  localparam int CB_TEN   = 12;
  localparam int CB_TXLEN = 13;
  localparam int CB_RXLEN = 16;
  localparam int CB_GO    = 19;

  typedef enum logic [1:0] {
    ENG_START = 2'd0,
    ENG_WRITE = 2'd1,
    ENG_READ  = 2'd2,
    ENG_STOP  = 2'd3
  } eng_cmd_e;

  typedef struct packed {
    logic              rd;
    logic              ten;
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  last;
  } xfer_t;
endpackage

// File: rtl/obr_regs.sv
module obr_regs
  import obr_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [REG_AW-1:0]          addr_i,
  input  logic [WORD_W-1:0]          wdata_i,
  output logic [WORD_W-1:0]          rdata_o,
  output logic                       irq_o,
  input  logic                       running_i,
  input  logic                       done_i,
  input  logic                       err_i,
  input  logic                       rx_we_i,
  input  logic [IDX_W-1:0]           rx_idx_i,
  input  logic [7:0]                 rx_byte_i,
  output logic                       launch_o,
  output xfer_t                      xfer_o,
  output logic [NUM_BYTES*8-1:0]     tx_data_o
);
  localparam int CTRL_W = CB_GO;

  logic [CTRL_W-1:0]           ctrl_q;
  logic                        err_q, cause_q, mask_q;
  logic [WORD_W-1:0]           tx_w [NUM_WORDS];
  logic [7:0]                  rx_b [NUM_BYTES];
  logic [NUM_BYTES*8-1:0]      rx_flat;
  logic                        ctrl_acc;

  assign ctrl_acc = we_i && (addr_i == RA_CTRL) && !running_i && !cause_q;
  assign launch_o = ctrl_acc && wdata_i[CB_GO] && (wdata_i[CB_WR] ^ wdata_i[CB_RD]);

  always_comb begin
    xfer_o.rd   = wdata_i[CB_RD];
    xfer_o.ten  = wdata_i[CB_TEN];
    xfer_o.addr = wdata_i[CB_ADDR +: ADDR_W];
    xfer_o.last = wdata_i[CB_RD] ? wdata_i[CB_RXLEN +: IDX_W] : wdata_i[CB_TXLEN +: IDX_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      err_q   <= 1'b0;
      cause_q <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      if (ctrl_acc) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (launch_o) err_q <= 1'b0;
      else if (done_i) err_q <= err_i;
      if (done_i) cause_q <= 1'b1;
      else if (we_i && addr_i == RA_CAUSE) cause_q <= cause_q & wdata_i[0];
      if (we_i && addr_i == RA_MASK) mask_q <= wdata_i[0];
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_tx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tx_w[w] <= '0;
      else if (we_i && !running_i && addr_i == REG_AW'(int'(RA_TX0) + w)) tx_w[w] <= wdata_i;
    end
    assign tx_data_o[w*WORD_W +: WORD_W] = tx_w[w];
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_rx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rx_b[b] <= '0;
      else if (launch_o) rx_b[b] <= '0;
      else if (rx_we_i && rx_idx_i == IDX_W'(b)) rx_b[b] <= rx_byte_i;
    end
    assign rx_flat[b*8 +: 8] = rx_b[b];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == RA_CTRL) begin
      rdata_o[CTRL_W-1:0] = ctrl_q;
      rdata_o[CB_GO]      = running_i;
    end else if (addr_i == RA_STAT)  rdata_o[0] = err_q;
    else if (addr_i == RA_CAUSE)     rdata_o[0] = cause_q;
    else if (addr_i == RA_MASK)      rdata_o[0] = mask_q;
    else if (addr_i >= RA_RX0)       rdata_o = rx_flat[(int'(addr_i) - int'(RA_RX0))*WORD_W +: WORD_W];
    else                             rdata_o = tx_data_o[(int'(addr_i) - int'(RA_TX0))*WORD_W +: WORD_W];
  end

  assign irq_o = cause_q & mask_q;

  assert_launch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_i) |-> $past(launch_o));
  assert_cause_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> cause_q);
  assert_tx_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i && $past(running_i) |-> $stable(tx_data_o));
endmodule

// File: rtl/obr_seq.sv
module obr_seq
  import obr_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    launch_i,
  input  xfer_t                   xfer_i,
  input  logic [NUM_BYTES*8-1:0]  tx_data_i,
  output logic                    running_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic                    rx_we_o,
  output logic [IDX_W-1:0]        rx_idx_o,
  output logic [7:0]              rx_byte_o,
  output logic                    eng_valid_o,
  output eng_cmd_e                eng_cmd_o,
  output logic [7:0]              eng_wdata_o,
  output logic                    eng_ack_o,
  input  logic                    eng_done_i,
  input  logic                    eng_nack_i,
  input  logic [7:0]              eng_rdata_i
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR1, S_ADDR2, S_DATA, S_STOP} state_e;

  state_e           state_q;
  xfer_t            xfer_q;
  logic [IDX_W-1:0] idx_q;
  logic             err_q, done_q;
  logic             last_byte;
  logic [7:0]       first_byte;

  assign last_byte  = (idx_q == xfer_q.last);
  assign first_byte = xfer_q.ten ? {5'b11110, xfer_q.addr[9:8], xfer_q.rd}
                                 : {xfer_q.addr[6:0], xfer_q.rd};

  always_comb begin
    eng_valid_o = (state_q != S_IDLE);
    eng_cmd_o   = ENG_START;
    eng_wdata_o = '0;
    eng_ack_o   = !last_byte;
    case (state_q)
      S_ADDR1: begin eng_cmd_o = ENG_WRITE; eng_wdata_o = first_byte; end
      S_ADDR2: begin eng_cmd_o = ENG_WRITE; eng_wdata_o = xfer_q.addr[7:0]; end
      S_DATA: begin
        eng_cmd_o   = xfer_q.rd ? ENG_READ : ENG_WRITE;
        eng_wdata_o = xfer_q.rd ? 8'h00 : tx_data_i[{idx_q, 3'b000} +: 8];
      end
      S_STOP:  eng_cmd_o = ENG_STOP;
      default: eng_cmd_o = ENG_START;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      xfer_q    <= '0;
      idx_q     <= '0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      rx_we_o   <= 1'b0;
      rx_idx_o  <= '0;
      rx_byte_o <= '0;
    end else begin
      done_q  <= 1'b0;
      rx_we_o <= 1'b0;
      case (state_q)
        S_IDLE: if (launch_i) begin
          xfer_q  <= xfer_i;
          idx_q   <= '0;
          err_q   <= 1'b0;
          state_q <= S_START;
        end
        S_START: if (eng_done_i) state_q <= S_ADDR1;
        S_ADDR1: if (eng_done_i) begin
          if (eng_nack_i) begin err_q <= 1'b1; state_q <= S_STOP; end
          else state_q <= xfer_q.ten ? S_ADDR2 : S_DATA;
        end
        S_ADDR2: if (eng_done_i) begin
          if (eng_nack_i) begin err_q <= 1'b1; state_q <= S_STOP; end
          else state_q <= S_DATA;
        end
        S_DATA: if (eng_done_i) begin
          if (xfer_q.rd) begin
            rx_we_o   <= 1'b1;
            rx_idx_o  <= idx_q;
            rx_byte_o <= eng_rdata_i;
          end
          if (!xfer_q.rd && eng_nack_i) begin
            err_q   <= 1'b1;
            state_q <= S_STOP;
          end else if (last_byte) state_q <= S_STOP;
          else idx_q <= idx_q + 1'b1;
        end
        S_STOP: if (eng_done_i) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign running_o = (state_q != S_IDLE) || done_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o && !eng_done_i |=> eng_valid_o && $stable(eng_cmd_o) && $stable(eng_wdata_o));
  assert_nack_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o && eng_done_i && eng_nack_i && eng_cmd_o == ENG_WRITE |=> eng_valid_o && eng_cmd_o == ENG_STOP);
  assert_one_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !eng_valid_o);
  assert_rx_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_we_o |-> rx_idx_o <= xfer_q.last && xfer_q.rd);
endmodule

// File: rtl/i2c_txn_bridge.sv
module i2c_txn_bridge
  import obr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              eng_valid_o,
  output logic [1:0]        eng_cmd_o,
  output logic [7:0]        eng_wdata_o,
  output logic              eng_ack_o,
  input  logic              eng_done_i,
  input  logic              eng_nack_i,
  input  logic [7:0]        eng_rdata_i
);
  logic                   launch, running, done, err, rx_we;
  logic [IDX_W-1:0]       rx_idx;
  logic [7:0]             rx_byte;
  xfer_t                  xfer;
  logic [NUM_BYTES*8-1:0] tx_data;
  eng_cmd_e               cmd;

  obr_regs i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .irq_o,
    .running_i(running), .done_i(done), .err_i(err),
    .rx_we_i(rx_we), .rx_idx_i(rx_idx), .rx_byte_i(rx_byte),
    .launch_o(launch), .xfer_o(xfer), .tx_data_o(tx_data)
  );

  obr_seq i_seq (
    .clk_i, .rst_ni,
    .launch_i(launch), .xfer_i(xfer), .tx_data_i(tx_data),
    .running_o(running), .done_o(done), .err_o(err),
    .rx_we_o(rx_we), .rx_idx_o(rx_idx), .rx_byte_o(rx_byte),
    .eng_valid_o, .eng_cmd_o(cmd), .eng_wdata_o, .eng_ack_o,
    .eng_done_i, .eng_nack_i, .eng_rdata_i
  );

  assign eng_cmd_o = cmd;

  assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done) || $past(reg_we_i));
endmodule

// File: tb/test_i2c_txn_bridge.sv
`timescale 1ns/1ps
module test_i2c_txn_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        eng_valid, eng_ack;
  logic [1:0]  eng_cmd;
  logic [7:0]  eng_wdata;
  logic        eng_done = 1'b0, eng_nack = 1'b0;
  logic [7:0]  eng_rdata = '0;

  int tests = 0, fails = 0;
  logic [1:0] log_cmd [32];
  logic [7:0] log_dat [32];
  logic       log_ack [32];
  int log_n = 0, nack_at = 99, rd_k = 0;

  always #2 clk = ~clk;

  i2c_txn_bridge i_i2c_txn_bridge (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .eng_valid_o(eng_valid), .eng_cmd_o(eng_cmd), .eng_wdata_o(eng_wdata),
    .eng_ack_o(eng_ack), .eng_done_i(eng_done), .eng_nack_i(eng_nack),
    .eng_rdata_i(eng_rdata)
  );

  // byte engine model: fixed latency, logs every command
  initial begin
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      eng_nack = 1'b0;
      if (rst_n && eng_valid) begin
        if (log_n < 32) begin
          log_cmd[log_n] = eng_cmd;
          log_dat[log_n] = eng_wdata;
          log_ack[log_n] = eng_ack;
        end
        repeat (2) @(negedge clk);
        eng_nack  = (eng_cmd == 2'd1) && (log_n == nack_at);
        eng_rdata = 8'hA0 + 8'(rd_k);
        if (eng_cmd == 2'd2) rd_k++;
        log_n++;
        eng_done = 1'b1;
      end
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(bit r, bit w, bit ten, int addr, int len);
    mk = 32'(1 << 19) | 32'(r) << 1 | 32'(w) | 32'(ten) << 12 | 32'(addr & 10'h3ff) << 2;
    if (r) mk |= 32'((len - 1) & 7) << 16;
    else   mk |= 32'((len - 1) & 7) << 13;
  endfunction

  task automatic clear_log();
    log_n = 0; rd_k = 0; nack_at = 99;
  endtask

  task automatic wait_done(string req);
    logic [31:0] d;
    for (int i = 0; i < 500; i++) begin
      rd(3'd2, d);
      if (d[0]) return;
    end
    check({req, " completion"}, 0, 1);
  endtask

  task automatic expect_cmd(string req, int i, logic [1:0] c, logic [7:0] dat);
    check({req, " cmd"}, 64'(log_cmd[i]), 64'(c));
    if (c == 2'd1) check({req, " byte"}, 64'(log_dat[i]), 64'(dat));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reg zero", 64'(d), 0);
    end
    check("R1 irq", 64'(irq), 0);
    check("R1 engine idle", 64'(eng_valid), 0);
  endtask

  task automatic t_write7();
    logic [31:0] d;
    clear_log();
    wr(3'd4, 32'h44332211);
    wr(3'd5, 32'h88776655);
    wr(3'd3, 32'h1);
    wr(3'd0, mk(0, 1, 0, 'h50, 4));
    wait_done("R3");
    check("R3 count", 64'(log_n), 7);
    expect_cmd("R3", 0, 2'd0, 0);
    expect_cmd("R3", 1, 2'd1, 8'hA0);
    expect_cmd("R3", 2, 2'd1, 8'h11);
    expect_cmd("R3", 5, 2'd1, 8'h44);
    expect_cmd("R3", 6, 2'd3, 0);
    rd(3'd1, d); check("R6 no error", 64'(d), 0);
    check("R7 irq set", 64'(irq), 1);
    wr(3'd2, 32'h0);
    rd(3'd2, d); check("R9 cause cleared", 64'(d), 0);
    check("R9 irq low", 64'(irq), 0);
  endtask

  task automatic t_write8();
    clear_log();
    wr(3'd0, mk(0, 1, 0, 'h12, 8));
    wait_done("R3 8B");
    check("R3 8B count", 64'(log_n), 11);
    expect_cmd("R3 8B", 1, 2'd1, 8'h24);
    expect_cmd("R3 8B", 6, 2'd1, 8'h55);
    expect_cmd("R3 8B", 9, 2'd1, 8'h88);
    wr(3'd2, 0);
  endtask

  task automatic t_read();
    logic [31:0] d;
    clear_log();
    wr(3'd0, mk(1, 0, 0, 'h3C, 6));
    wait_done("R5");
    check("R5 count", 64'(log_n), 9);
    expect_cmd("R5", 1, 2'd1, 8'h79);
    check("R5 read cmd", 64'(log_cmd[2]), 2);
    check("R5 ack mid", 64'(log_ack[6]), 1);
    check("R5 nack last", 64'(log_ack[7]), 0);
    rd(3'd6, d); check("R5 rx low", 64'(d), 64'h A3A2A1A0);
    rd(3'd7, d); check("R5 rx high", 64'(d), 64'h0000A5A4);
    wr(3'd2, 0);
  endtask

  task automatic t_ten();
    logic [31:0] d;
    clear_log();
    wr(3'd0, mk(0, 1, 1, 'h2B5, 1));
    wait_done("R4");
    check("R4 count", 64'(log_n), 5);
    expect_cmd("R4", 1, 2'd1, 8'hF4);
    expect_cmd("R4", 2, 2'd1, 8'hB5);
    expect_cmd("R4", 3, 2'd1, 8'h11);
    wr(3'd2, 0);
    clear_log();
    wr(3'd0, mk(1, 0, 1, 'h2B5, 1));
    wait_done("R4 read");
    expect_cmd("R4 read", 1, 2'd1, 8'hF5);
    check("R4 read single nack", 64'(log_ack[3]), 0);
    rd(3'd6, d); check("R5 rx cleared above", 64'(d), 64'h000000A0);
    wr(3'd2, 0);
  endtask

  task automatic t_nack();
    logic [31:0] d;
    clear_log(); nack_at = 1;
    wr(3'd0, mk(0, 1, 0, 'h50, 4));
    wait_done("R6 addr");
    check("R6 addr count", 64'(log_n), 3);
    check("R6 addr stop", 64'(log_cmd[2]), 3);
    rd(3'd1, d); check("R6 addr err", 64'(d), 1);
    wr(3'd2, 0);
    clear_log(); nack_at = 3;
    wr(3'd0, mk(0, 1, 0, 'h50, 8));
    rd(3'd1, d); check("R11 err cleared at launch", 64'(d), 0);
    wait_done("R6 data");
    check("R6 data count", 64'(log_n), 5);
    check("R6 data stop", 64'(log_cmd[4]), 3);
    rd(3'd1, d); check("R6 data err", 64'(d), 1);
    wr(3'd2, 0);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    int n;
    clear_log();
    wr(3'd0, mk(0, 1, 0, 'h50, 8));
    repeat (6) @(negedge clk);
    rd(3'd0, d); check("R2 running readback", 64'(d[19]), 1);
    wr(3'd0, mk(1, 0, 0, 'h22, 2));
    wr(3'd4, 32'hDEADBEEF);
    wait_done("R8");
    check("R8 only first", 64'(log_n), 11);
    expect_cmd("R8 tx frozen", 2, 2'd1, 8'h11);
    n = log_n;
    wr(3'd0, mk(1, 0, 0, 'h22, 2));
    repeat (20) @(negedge clk);
    check("R8 cause pending", 64'(log_n), 64'(n));
    wr(3'd2, 0);
    clear_log();
    wr(3'd0, mk(1, 0, 0, 'h22, 2));
    wait_done("R8 rearm");
    check("R8 rearm count", 64'(log_n), 5);
    wr(3'd2, 0);
  endtask

  task automatic t_bad_dir();
    clear_log();
    wr(3'd0, mk(1, 1, 0, 'h22, 2));
    repeat (12) @(negedge clk);
    check("R10 both dirs", 64'(log_n), 0);
    wr(3'd0, mk(0, 0, 0, 'h22, 2));
    repeat (12) @(negedge clk);
    check("R10 no dir", 64'(log_n), 0);
    wr(3'd0, 32'h0000_0141);
    repeat (12) @(negedge clk);
    check("R2 no launch bit", 64'(log_n), 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(3'd3, 0);
    clear_log();
    wr(3'd0, mk(0, 1, 0, 'h50, 1));
    wait_done("R7 masked");
    check("R7 masked irq", 64'(irq), 0);
    wr(3'd3, 1);
    check("R7 unmask irq", 64'(irq), 1);
    wr(3'd2, 1);
    rd(3'd2, d); check("R9 write one keeps", 64'(d), 1);
    wr(3'd2, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write7();
    t_write8();
    t_read();
    t_ten();
    t_nack();
    t_busy();
    t_bad_dir();
    t_mask();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule